// File: doc/BRIEF.md
# Limit Monitor with Fault Count

This block watches the results of a power and temperature measurement front end and decides when a result is out of range. It holds one check for each of: shunt voltage above a high limit, shunt voltage below a low limit, bus voltage above a high limit, bus voltage below a low limit, power above a limit, local temperature above a limit, and each remote temperature above its own limit. A check is evaluated only on the cycle when its channel's conversion-done strobe is high. A violating result must repeat for a programmable number of consecutive conversions before the check's flag is raised.

Temperature checks carry hysteresis. A temperature trips when it rises above its limit plus half the hysteresis value. A remote channel also trips when its sensor diode is reported open during that conversion. Flags either latch, until a status read or a serviced alert clears them, or track the measurements, with a lower release threshold for temperatures. An active-low alert output is asserted while any flag that has its enable bit set is high.

Top module: `lmon_top`

## Requirements
- R1: Shunt results and limits are signed 16-bit. On a shunt strobe, a result greater than the high limit is a positive-shunt violation. A result less than the low limit is a negative-shunt violation.
- R2: Bus results, bus limits, power results and the power limit are unsigned 16-bit. On a bus strobe, a result above the high limit is a positive violation and a result below the low limit is a negative violation. On a power strobe, a result above the limit is a power violation.
- R3: Temperatures are 13-bit two's complement. On a local or remote strobe, the result is a violation when it is greater than the limit plus floor(hysteresis/2). The sum is taken without overflow.
- R4: On a remote strobe with that channel's open-diode input high, the remote check is a violation whatever the result.
- R5: The fault-count code picks how many consecutive violating strobes raise a flag: 00 picks 1, 01 picks 2, 10 picks 4 and 11 picks 6. A non-violating strobe restarts that check's count.
- R6: Without its channel's strobe, a check's count and flag do not change, whatever its result and limit inputs do.
- R7: With latch_mode high, a raised flag stays set through later non-violating strobes. It clears on stat_rd. If a flag is raised in the same cycle as a clear, the raise wins.
- R8: With latch_mode low, a temperature flag clears on a strobe whose result is below the limit minus floor(hysteresis/2) with no open diode. An electrical flag clears on any non-violating strobe. Results between the two thresholds, and stat_rd, leave the flag unchanged.
- R9: Flag bit order, from the top: shunt positive (8), shunt negative (7), bus positive (6), bus negative (5), power (4), local (3), remote 1 (2), remote 2 (1), remote 3 (0). alert_n is low exactly when some flag is high and its alert_en bit is also high.
- R10: After reset all flags are 0, all counts are 0 and alert_n is 1.
- R11: In latch mode, alert_ack clears the latched flags only while alert_n is low. An acknowledge while alert_n is high leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fc_code | input | 2 | Fault-count code |
| latch_mode | input | 1 | 1 = latched flags, 0 = transparent flags |
| hyst | input | HW (8) | Temperature hysteresis in temperature LSBs |
| alert_en | input | NCHK (9) | Per-flag alert enable, same bit order as flags |
| stat_rd | input | 1 | Status-read event (clears latched flags) |
| alert_ack | input | 1 | Alert-response event |
| shunt_res | input | DW (16) | Shunt result, signed |
| shunt_hi | input | DW (16) | Shunt high limit, signed |
| shunt_lo | input | DW (16) | Shunt low limit, signed |
| shunt_done | input | 1 | Shunt conversion strobe |
| bus_res | input | DW (16) | Bus result, unsigned |
| bus_hi | input | DW (16) | Bus high limit |
| bus_lo | input | DW (16) | Bus low limit |
| bus_done | input | 1 | Bus conversion strobe |
| pwr_res | input | DW (16) | Power result, unsigned |
| pwr_lim | input | DW (16) | Power limit |
| pwr_done | input | 1 | Power strobe |
| loc_res | input | TW (13) | Local temperature, signed |
| loc_lim | input | TW (13) | Local temperature limit, signed |
| loc_done | input | 1 | Local conversion strobe |
| rmt_res | input | NR×TW (3×13) | Remote temperatures, index 0 = remote 1 |
| rmt_lim | input | NR×TW (3×13) | Remote limits |
| rmt_done | input | NR (3) | Remote conversion strobes |
| rmt_open | input | NR (3) | Open-diode indications |
| flags | output | NCHK (9) | Limit flags |
| alert_n | output | 1 | Alert, active low |

## Verification
The assertions check on every cycle that a count stays still without a strobe, and that a count is zero after a non-violating strobe. They also check that a raise always shows up as a set flag on the next cycle, that a latched flag cannot drop without a clear event, and that alert_n agrees with the enabled flags. Some behaviour shows only in the bench's scenarios: the exact trip points of the temperature comparison with hysteresis and signed values, the count needed for each fault-count code, the release band in transparent mode, and the acknowledge that is ignored while no enabled flag is up.

// File: rtl/lmon_pkg.sv
package lmon_pkg;
  localparam int CW = 3;

  // consecutive violations needed for each fault-count code
  function automatic logic [CW-1:0] fc_need(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd6;
    endcase
  endfunction

  // result above limit plus half hysteresis, evaluated two bits wider
  function automatic logic temp_over(input logic signed [12:0] r,
                                     input logic signed [12:0] l,
                                     input logic [7:0] h);
    logic signed [14:0] re, le, he;
    re = 15'(r);
    le = 15'(l);
    he = $signed({8'b0, h[7:1]});
    return re > (le + he);
  endfunction

  // result below limit minus half hysteresis (release threshold)
  function automatic logic temp_under(input logic signed [12:0] r,
                                      input logic signed [12:0] l,
                                      input logic [7:0] h);
    logic signed [14:0] re, le, he;
    re = 15'(r);
    le = 15'(l);
    he = $signed({8'b0, h[7:1]});
    return re < (le - he);
  endfunction
endpackage

// File: rtl/lmon_qual.sv
module lmon_qual
  import lmon_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          viol,
  input  logic [CW-1:0] need,
  output logic          trip
);
  localparam logic [CW-1:0] CMAX = '1;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
  assign trip    = done & viol & (cnt_inc >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (done) cnt_q <= viol ? cnt_inc : '0;
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !viol) |=> (cnt_q == '0));                              // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(cnt_q));                                       // R6
endmodule

// File: rtl/lmon_flag.sv
module lmon_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic done,
  input  logic calm,
  input  logic latch,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             flag_q <= 1'b0;
    else if (trip)          flag_q <= 1'b1;
    else if (latch) begin
      if (clr)              flag_q <= 1'b0;
    end else if (done && calm) flag_q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> flag_q);                                                // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && flag_q && !clr) |=> flag_q);                           // R7
  AST_TRANSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch && flag_q && !(done && calm)) |=> flag_q);               // R8
endmodule

// File: rtl/lmon_top.sv
module lmon_top
  import lmon_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 13,
  parameter int HW = 8,
  parameter int NR = 3,
  localparam int NCHK = 6 + NR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             fc_code,
  input  logic                   latch_mode,
  input  logic [HW-1:0]          hyst,
  input  logic [NCHK-1:0]        alert_en,
  input  logic                   stat_rd,
  input  logic                   alert_ack,
  input  logic [DW-1:0]          shunt_res,
  input  logic [DW-1:0]          shunt_hi,
  input  logic [DW-1:0]          shunt_lo,
  input  logic                   shunt_done,
  input  logic [DW-1:0]          bus_res,
  input  logic [DW-1:0]          bus_hi,
  input  logic [DW-1:0]          bus_lo,
  input  logic                   bus_done,
  input  logic [DW-1:0]          pwr_res,
  input  logic [DW-1:0]          pwr_lim,
  input  logic                   pwr_done,
  input  logic [TW-1:0]          loc_res,
  input  logic [TW-1:0]          loc_lim,
  input  logic                   loc_done,
  input  logic [NR-1:0][TW-1:0]  rmt_res,
  input  logic [NR-1:0][TW-1:0]  rmt_lim,
  input  logic [NR-1:0]          rmt_done,
  input  logic [NR-1:0]          rmt_open,
  output logic [NCHK-1:0]        flags,
  output logic                   alert_n
);
  localparam int I_SHP = NCHK - 1;
  localparam int I_SHN = NCHK - 2;
  localparam int I_BVP = NCHK - 3;
  localparam int I_BVN = NCHK - 4;
  localparam int I_PWR = NCHK - 5;
  localparam int I_LOC = NCHK - 6;

  logic [NCHK-1:0] viol, calm, done_v, trip_v;
  logic [CW-1:0]   need;
  logic            clr_evt;

  assign need    = fc_need(fc_code);
  assign clr_evt = stat_rd | (alert_ack & ~alert_n);

  // electrical checks: release on any clean strobe
  always_comb begin
    viol[I_SHP] = $signed(shunt_res) > $signed(shunt_hi);
    viol[I_SHN] = $signed(shunt_res) < $signed(shunt_lo);
    viol[I_BVP] = bus_res > bus_hi;
    viol[I_BVN] = bus_res < bus_lo;
    viol[I_PWR] = pwr_res > pwr_lim;
    viol[I_LOC] = temp_over(13'(loc_res), 13'(loc_lim), 8'(hyst));
    calm[I_SHP] = !viol[I_SHP];
    calm[I_SHN] = !viol[I_SHN];
    calm[I_BVP] = !viol[I_BVP];
    calm[I_BVN] = !viol[I_BVN];
    calm[I_PWR] = !viol[I_PWR];
    calm[I_LOC] = temp_under(13'(loc_res), 13'(loc_lim), 8'(hyst));
    done_v[I_SHP] = shunt_done;
    done_v[I_SHN] = shunt_done;
    done_v[I_BVP] = bus_done;
    done_v[I_BVN] = bus_done;
    done_v[I_PWR] = pwr_done;
    done_v[I_LOC] = loc_done;
  end

  // remote channel i sits at flag index NR-1-i
  for (genvar i = 0; i < NR; i++) begin : g_rmt
    localparam int IX = NR - 1 - i;
    assign viol[IX]   = rmt_open[i] |
                        temp_over(13'(rmt_res[i]), 13'(rmt_lim[i]), 8'(hyst));
    assign calm[IX]   = !rmt_open[i] &
                        temp_under(13'(rmt_res[i]), 13'(rmt_lim[i]), 8'(hyst));
    assign done_v[IX] = rmt_done[i];
  end

  for (genvar k = 0; k < NCHK; k++) begin : g_chk
    lmon_qual u_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .done (done_v[k]),
      .viol (viol[k]),
      .need (need),
      .trip (trip_v[k])
    );
    lmon_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .trip  (trip_v[k]),
      .done  (done_v[k]),
      .calm  (calm[k]),
      .latch (latch_mode),
      .clr   (clr_evt),
      .flag_q(flags[k])
    );
  end

  assign alert_n = ~|(flags & alert_en);

  AST_ALERT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & alert_en) == '0) |-> alert_n);                         // R9
  AST_ALERT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & alert_en) != '0) |-> !alert_n);                        // R9
  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && alert_n && alert_ack && !stat_rd && trip_v == '0)
      |=> $stable(flags));                                           // R11
endmodule

// File: tb/lmon_top_bench.sv
module lmon_top_bench;
  localparam int CLK_P = 10;
  localparam int NR = 3;
  localparam int NCHK = 9;

  logic clk = 0, rst_n = 0;
  logic [1:0] fc_code = 2'b00;
  logic latch_mode = 1'b1;
  logic [7:0] hyst = 8'd0;
  logic [NCHK-1:0] alert_en = '1;
  logic stat_rd = 0, alert_ack = 0;
  logic [15:0] shunt_res = 0, shunt_hi = 16'h7FFF, shunt_lo = 16'h8000;
  logic shunt_done = 0;
  logic [15:0] bus_res = 16'd100, bus_hi = 16'hFFFF, bus_lo = 16'd0;
  logic bus_done = 0;
  logic [15:0] pwr_res = 0, pwr_lim = 16'hFFFF;
  logic pwr_done = 0;
  logic [12:0] loc_res = 0, loc_lim = 13'd4095;
  logic loc_done = 0;
  logic [NR-1:0][12:0] rmt_res = '0;
  logic [NR-1:0][12:0] rmt_lim = {3{13'd4095}};
  logic [NR-1:0] rmt_done = '0, rmt_open = '0;
  logic [NCHK-1:0] flags;
  logic alert_n;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  lmon_top u_lmon_top (.*);

  // {result, limit, hysteresis, expected local flag}
  localparam logic [34:0] VEC [0:9] = '{
    {13'd100,   13'd100,   8'd4,   1'b0},
    {13'd102,   13'd100,   8'd4,   1'b0},
    {13'd103,   13'd100,   8'd4,   1'b1},
    {13'd101,   13'd100,   8'd3,   1'b0},
    {13'd102,   13'd100,   8'd3,   1'b1},
    {13'h1FFB,  13'h1FF8,  8'd0,   1'b1},
    {13'h1FF7,  13'h1FF8,  8'd0,   1'b0},
    {13'h0FFF,  13'h0FFF,  8'd255, 1'b0},
    {13'h1000,  13'h0FFF,  8'd0,   1'b0},
    {13'h0FFF,  13'h1000,  8'd255, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic do_rd;  stat_rd = 1;  tick(); stat_rd = 0;  tick(); endtask
  task automatic do_ack; alert_ack = 1; tick(); alert_ack = 0; tick(); endtask
  task automatic p_shunt; shunt_done = 1; tick(); shunt_done = 0; endtask
  task automatic p_bus;   bus_done = 1;   tick(); bus_done = 0;   endtask
  task automatic p_pwr;   pwr_done = 1;   tick(); pwr_done = 0;   endtask
  task automatic p_loc;   loc_done = 1;   tick(); loc_done = 0;   endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R10 reset flags", 32'(flags), 0);
    check("R10 reset alert_n", 32'(alert_n), 1);
    rst_n = 1; tick();

    // R3 vector walk on local channel, latch mode, code 00
    for (int v = 0; v < 10; v++) begin
      loc_res = VEC[v][34:22]; loc_lim = VEC[v][21:9]; hyst = VEC[v][8:1];
      do_rd();
      p_loc();
      check($sformatf("R3 vector %0d", v), 32'(flags[3]), 32'(VEC[v][0]));
    end
    loc_res = 0; loc_lim = 13'd4095; hyst = 0; p_loc(); do_rd();
    check("R7 clear by stat_rd", 32'(flags), 0);

    // R1 shunt signed
    shunt_hi = 16'd400; shunt_lo = 16'hFE70;
    shunt_res = 16'd500; p_shunt();
    check("R1 shunt positive", 32'(flags[8:7]), 2);
    do_rd();
    shunt_res = 16'hFE0C; p_shunt();
    check("R1 shunt negative", 32'(flags[8:7]), 1);
    do_rd();
    shunt_res = 16'hFE70; p_shunt();
    check("R1 at low limit no trip", 32'(flags), 0);

    // R6 no strobe no change
    shunt_res = 16'd9000; tick(); tick();
    check("R6 no strobe", 32'(flags), 0);
    shunt_res = 0; p_shunt();

    // R2 bus and power unsigned
    bus_hi = 16'd8000; bus_lo = 16'd50;
    bus_res = 16'd9000; p_bus();
    check("R2 bus positive", 32'(flags[6:5]), 2);
    do_rd();
    bus_res = 16'd10; p_bus();
    check("R2 bus negative", 32'(flags[6:5]), 1);
    do_rd();
    pwr_lim = 16'd1000; pwr_res = 16'hF000; p_pwr();
    check("R2 power over", 32'(flags[4]), 1);
    pwr_res = 0; p_pwr(); do_rd();
    bus_res = 16'd100; p_bus();

    // R4 open diode on remote 1 -> flag index 2
    rmt_open[0] = 1; rmt_done[0] = 1; tick(); rmt_done[0] = 0; rmt_open[0] = 0;
    check("R4 open diode remote1", 32'(flags[2:0]), 4);
    do_rd();
    check("R9 order after clear", 32'(flags), 0);
    rmt_res[2] = 13'd200; rmt_lim[2] = 13'd100;
    rmt_done[2] = 1; tick(); rmt_done[2] = 0;
    check("R9 remote3 at bit 0", 32'(flags), 1);
    rmt_res[2] = 0; rmt_done[2] = 1; tick(); rmt_done[2] = 0; do_rd();

    // R5 fault counts on bus channel
    fc_code = 2'b01; bus_res = 16'd9000;
    p_bus(); check("R5 code01 one", 32'(flags[6]), 0);
    p_bus(); check("R5 code01 two", 32'(flags[6]), 1);
    bus_res = 16'd100; p_bus(); do_rd();
    fc_code = 2'b10; bus_res = 16'd9000;
    repeat (3) p_bus(); check("R5 code10 three", 32'(flags[6]), 0);
    p_bus(); check("R5 code10 four", 32'(flags[6]), 1);
    bus_res = 16'd100; p_bus(); do_rd();
    fc_code = 2'b11; bus_res = 16'd9000;
    repeat (5) p_bus(); check("R5 code11 five", 32'(flags[6]), 0);
    p_bus(); check("R5 code11 six", 32'(flags[6]), 1);
    bus_res = 16'd100; p_bus(); do_rd();
    fc_code = 2'b01;
    bus_res = 16'd9000; p_bus(); bus_res = 16'd100; p_bus();
    bus_res = 16'd9000; p_bus();
    check("R5 restart after clean", 32'(flags[6]), 0);
    p_bus(); check("R5 restart then two", 32'(flags[6]), 1);
    bus_res = 16'd100; p_bus(); do_rd();
    fc_code = 2'b00;

    // R7 latch hold and set wins
    pwr_res = 16'hF000; p_pwr(); pwr_res = 0; p_pwr();
    check("R7 latched holds", 32'(flags[4]), 1);
    do_rd();
    check("R7 stat_rd clears", 32'(flags[4]), 0);
    pwr_res = 16'hF000; pwr_done = 1; stat_rd = 1; tick(); pwr_done = 0; stat_rd = 0;
    check("R7 set wins over clear", 32'(flags[4]), 1);
    pwr_res = 0; p_pwr();

    // R11 / R9 acknowledge and enable
    alert_en = '0; tick();
    check("R9 masked alert high", 32'(alert_n), 1);
    do_ack();
    check("R11 ack ignored", 32'(flags[4]), 1);
    alert_en = 9'h010; tick();
    check("R9 enabled alert low", 32'(alert_n), 0);
    do_ack();
    check("R11 ack clears", 32'(flags[4]), 0);
    alert_en = '1;

    // R8 transparent band on local channel
    latch_mode = 0; loc_lim = 13'd100; hyst = 8'd4;
    loc_res = 13'd103; p_loc();
    check("R8 trip", 32'(flags[3]), 1);
    loc_res = 13'd99; p_loc();
    check("R8 inside band holds", 32'(flags[3]), 1);
    do_rd();
    check("R8 stat_rd no effect", 32'(flags[3]), 1);
    loc_res = 13'd97; p_loc();
    check("R8 release below band", 32'(flags[3]), 0);
    check("R10 alert idle", 32'(alert_n), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule